// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two unsigned words one bit per clock. Two right-shifting registers hold the operands. A single full adder takes their lowest bits and a stored carry. The sum bit enters the top of the augend register, in the position that the shift has just freed. After one pass of WIDTH shift clocks, that register holds the sum and a carry flip-flop holds the bit that overflowed.

The carry survives from one pass to the next. To sum more than two operands, load the next operand into the addend register, leave the running total where it is, and start another pass. The carry left by the previous pass feeds into the new one unless software clears it. A cycle counter ends each pass on its own and marks the end with a one-cycle done pulse.

Top module: `serial_accum`

## Requirements
- R1: While reset is asserted, and after it is released, the accumulator output, the carry output and the done flag all read 0.
- R2: While no pass is running, a load strobe on either operand port writes that port's value into its register at the next clock edge. The accumulator output shows the new augend one cycle after the strobe.
- R3: A start request while idle makes the same clock edge the first of exactly WIDTH shift edges. Done is high for exactly one cycle, the cycle right after the last shift edge, and it is low before that.
- R4: When done is high, the accumulator holds bits WIDTH-1..0 of augend + addend + carry-in, and the carry output holds bit WIDTH of that sum. Bits are added least significant first.
- R5: With WIDTH=4, a clear carry, augend 1011 and addend 1001 give 0100 in the accumulator and a carry of 1.
- R6: After a pass, loading only a new addend and starting again adds that addend and the kept carry to the previous total.
- R7: A clear-carry strobe while idle sets the carry to 0 at the next edge.
- R8: While a pass is running, the load strobes, the clear-carry strobe and the start request are ignored. The result and the done timing are the same as without them.
- R9: The addend register fills with 0 from the top as it shifts, so a second pass with no new addend adds only the kept carry.
- R10: While idle, the carry keeps its value across operand loads unless clear-carry is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| a_data_i | input | WIDTH | Parallel value for the augend/accumulator register |
| b_data_i | input | WIDTH | Parallel value for the addend register |
| load_a_i | input | 1 | Load strobe for the augend register (idle only) |
| load_b_i | input | 1 | Operand-load strobe for the addend register (idle only) |
| clr_carry_i | input | 1 | Clears the carry flip-flop (idle only) |
| start_i | input | 1 | Starts a pass of WIDTH shift clocks |
| done_o | output | 1 | One-cycle pulse that marks a finished pass |
| acc_o | output | WIDTH | Current contents of the accumulator register |
| carry_o | output | 1 | Current contents of the carry flip-flop |

## Verification
All inputs are driven at the falling edge, and all outputs are sampled at a later falling edge. Each check therefore sees the result of a known number of rising edges. A load or a carry clear shows at the next falling edge, one rising edge later. If start is applied at falling edge n, done and the final sum and carry are checked at falling edge n+WIDTH. Done is checked low at n+WIDTH-1 and again at n+WIDTH+1. In the ignore test, the disallowed strobes are held over falling edges n+1 to n+WIDTH-1, so they fall entirely inside the running pass. The clear-carry strobe is placed where the carry is 1 mid-pass, so obeying it would change the sum.

// File: rtl/serial_accum_pkg.sv
package serial_accum_pkg;
  localparam int unsigned DEF_WIDTH = 4;

  // result of a one-bit addition step
  typedef struct packed {
    logic cout;
    logic sum;
  } fa_out_t;
endpackage

// File: rtl/sa_rst_sync.sv
module sa_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sa_full_adder.sv
module sa_full_adder
  import serial_accum_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    ci_i,
  output fa_out_t res_o
);
  always_comb begin
    res_o.sum  = a_i ^ b_i ^ ci_i;
    res_o.cout = (a_i & b_i) | (a_i & ci_i) | (b_i & ci_i);
  end
endmodule

// File: rtl/sa_shreg.sv
module sa_shreg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         upd;

  // shift wins over load
  always_comb begin
    q_nxt = q;
    upd   = shift_en | load_en;
    if (shift_en)     q_nxt = {ser_in, q[W-1:1]};
    else if (load_en) q_nxt = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_nxt;
  end
endmodule

// File: rtl/sa_seq_ctrl.sv
module sa_seq_ctrl #(
  parameter int unsigned W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic shift_o,
  output logic done_o
);
  localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          busy_q, busy_nxt;
  logic          done_nxt;

  always_comb begin
    shift_o  = busy_q | start_i;
    cnt_nxt  = cnt_q;
    busy_nxt = busy_q;
    done_nxt = 1'b0;
    if (shift_o) begin
      if (cnt_q == LAST) begin
        cnt_nxt  = '0;
        busy_nxt = 1'b0;
        done_nxt = 1'b1;
      end else begin
        cnt_nxt  = cnt_q + 1'b1;
        busy_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      busy_q <= busy_nxt;
      done_o <= done_nxt;
    end
  end
endmodule

// File: rtl/serial_accum.sv
module serial_accum
  import serial_accum_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_data_i,
  input  logic [WIDTH-1:0] b_data_i,
  input  logic             load_a_i,
  input  logic             load_b_i,
  input  logic             clr_carry_i,
  input  logic             start_i,
  output logic             done_o,
  output logic [WIDTH-1:0] acc_o,
  output logic             carry_o
);
  logic             rst_q_n;
  logic             shift_en;
  logic [WIDTH-1:0] b_q;
  logic             carry_q, carry_nxt;
  fa_out_t          fa;

  sa_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_q_n)
  );

  sa_seq_ctrl #(.W(WIDTH)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .start_i (start_i),
    .shift_o (shift_en),
    .done_o  (done_o)
  );

  // augend register doubles as the accumulator
  sa_shreg #(.W(WIDTH)) i_reg_a (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load_en  (load_a_i & ~shift_en),
    .load_val (a_data_i),
    .shift_en (shift_en),
    .ser_in   (fa.sum),
    .q        (acc_o)
  );

  sa_shreg #(.W(WIDTH)) i_reg_b (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load_en  (load_b_i & ~shift_en),
    .load_val (b_data_i),
    .shift_en (shift_en),
    .ser_in   (1'b0),
    .q        (b_q)
  );

  sa_full_adder i_fa (
    .a_i   (acc_o[0]),
    .b_i   (b_q[0]),
    .ci_i  (carry_q),
    .res_o (fa)
  );

  always_comb begin
    carry_nxt = carry_q;
    if (shift_en)         carry_nxt = fa.cout;
    else if (clr_carry_i) carry_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) carry_q <= 1'b0;
    else          carry_q <= carry_nxt;
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         shift_en,
  input logic         clr_carry,
  input logic [W-1:0] acc,
  input logic [W-1:0] b_q,
  input logic         carry,
  input logic         done
);
  // R3: done lasts a single cycle
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: done only follows a shift edge
  assert_done_after_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(shift_en));

  // R4: sum bit enters the top, the rest moves down
  assert_sum_into_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (acc[W-1] == (($countones({$past(acc[0]), $past(b_q[0]), $past(carry)}) % 2) == 1))
              && (acc[W-2:0] == $past(acc[W-1:1])));

  // R4: carry takes the majority of the three inputs
  assert_carry_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> carry == ($countones({$past(acc[0]), $past(b_q[0]), $past(carry)}) >= 2));

  // R8 / R9: addend shifts with zero fill, loads cannot touch it
  assert_b_zero_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> b_q == ($past(b_q) >> 1));

  // R10: idle carry holds without a clear
  assert_carry_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr_carry) |=> $stable(carry));

  // R7: idle clear empties the carry
  assert_carry_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && clr_carry) |=> !carry);
endmodule

bind serial_accum sa_checker #(.W(WIDTH)) i_sa_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .shift_en  (shift_en),
  .clr_carry (clr_carry_i),
  .acc       (acc_o),
  .b_q       (b_q),
  .carry     (carry_o),
  .done      (done_o)
);

// File: tb/test_serial_accum.sv
module test_serial_accum;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic         load_a = 1'b0, load_b = 1'b0, clr_c = 1'b0, start = 1'b0;
  logic         done;
  logic [W-1:0] acc;
  logic         carry;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  serial_accum #(.WIDTH(W)) i_serial_accum (
    .clk(clk), .rst_n(rst_n), .a_data_i(a_data), .b_data_i(b_data),
    .load_a_i(load_a), .load_b_i(load_b), .clr_carry_i(clr_c),
    .start_i(start), .done_o(done), .acc_o(acc), .carry_o(carry)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // idle loads of both operands and optional carry clear, one cycle
  task automatic load_ops(input logic [W-1:0] a, input logic [W-1:0] b, input logic clr);
    @(negedge clk);
    a_data = a; b_data = b; load_a = 1'b1; load_b = 1'b1; clr_c = clr;
    @(negedge clk);
    load_a = 1'b0; load_b = 1'b0; clr_c = 1'b0;
  endtask

  // one pass with done timing and result checks
  task automatic run_op(input string req, input int ea, input int ec);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W - 2) @(negedge clk);
    chk({req, " R3 done early"}, done, 0);
    @(negedge clk);
    chk({req, " R3 done"}, done, 1);
    chk({req, " sum"}, acc, ea);
    chk({req, " carry"}, carry, ec);
    @(negedge clk);
    chk({req, " R3 done drop"}, done, 0);
  endtask

  task automatic t_reset;
    chk("R1 acc in reset", acc, 0);
    chk("R1 carry in reset", carry, 0);
    chk("R1 done in reset", done, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 acc after reset", acc, 0);
    chk("R1 carry after reset", carry, 0);
    chk("R1 done after reset", done, 0);
  endtask

  task automatic t_worked;
    load_ops(4'b1011, 4'b1001, 1'b1);
    chk("R2 augend load", acc, 4'b1011);
    run_op("R5", 4'b0100, 1);
  endtask

  task automatic t_accum;
    @(negedge clk);
    b_data = 4'b1110; load_b = 1'b1;
    @(negedge clk);
    load_b = 1'b0;
    chk("R10 carry kept over load", carry, 1);
    chk("R6 total kept", acc, 4'b0100);
    run_op("R6", 4'b0011, 1);
  endtask

  task automatic t_zero_fill;
    run_op("R9", 4'b0100, 0);
  endtask

  task automatic t_clear;
    load_ops(4'b1111, 4'b0001, 1'b1);
    run_op("R4 wrap", 4'b0000, 1);
    @(negedge clk); clr_c = 1'b1;
    @(negedge clk); clr_c = 1'b0;
    chk("R7 carry cleared", carry, 0);
    load_ops(4'b0001, 4'b0001, 1'b0);
    run_op("R7 after clear", 4'b0010, 0);
  endtask

  task automatic t_ignore;
    load_ops(4'b0011, 4'b0101, 1'b1);
    start = 1'b1;
    @(negedge clk);
    a_data = 4'b1111; b_data = 4'b1111;
    load_a = 1'b1; load_b = 1'b1; clr_c = 1'b1;
    repeat (W - 2) @(negedge clk);
    chk("R8 done early", done, 0);
    start = 1'b0; load_a = 1'b0; load_b = 1'b0; clr_c = 1'b0;
    @(negedge clk);
    chk("R8 done", done, 1);
    chk("R8 sum", acc, 4'b1000);
    chk("R8 carry", carry, 0);
    @(negedge clk);
    chk("R8 done drop", done, 0);
    chk("R8 no second pass", acc, 4'b1000);
  endtask

  task automatic t_patterns;
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] a, b;
      logic [W:0]   s;
      a = W'(i * 3 + 1);
      b = W'(i * 5 + 2);
      s = {1'b0, a} + {1'b0, b};
      load_ops(a, b, 1'b1);
      run_op("R4", s[W-1:0], s[W]);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_worked();
    t_accum();
    t_zero_fill();
    t_clear();
    t_ignore();
    t_patterns();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule